// File: doc/BRIEF.md
# Execute-Stage Utilization Monitor

This block sits next to the execute stage of a compute unit that has a parameterised number of vector SIMD units plus one global-memory pipe and one local-memory pipe. Each execution unit owns one dispatch slot. On every clock the monitor looks at all slots. Any slot holding an instruction is consumed in that same cycle, and the monitor returns a clear strobe for it. From the same snapshot it updates a set of saturating performance counters and two histograms that describe how the units are used.

The slot interface follows valid/ready rules. `slot_valid[u]` is the valid bit and `slot_clear[u]` is the matching ready/consume strobe. The monitor never applies back-pressure: a valid slot is always taken in the cycle it is presented. A producer that sees `slot_clear[u]` high may therefore drop or refill that slot on the next edge. Besides plain busy counts, the monitor records cycles in which a unit was idle although work was waiting. For the SIMD units this uses a per-unit ready flag. For the memory pipes it uses availability credits that are spent as they are counted. The monitor also counts active-to-idle transitions and bins the lengths of idle runs. All counters are read through a single combinational read port.

Top module: `exu_util_monitor`

## Requirements
- R1: `slot_clear[u]` is high in exactly the cycles in which `slot_valid[u]` is high. Unit indices are: SIMD units 0..N-1, global-memory pipe N, local-memory pipe N+1.
- R2: On each edge where `slot_valid[u]` is high, the busy counter of unit u goes up by one.
- R3: An idle SIMD unit u (slot empty) increments its stall counter only when `simd_ready[u]` is high in that cycle.
- R4: An idle memory pipe increments its stall counter only when its credit is non-zero, and that credit is then lowered by one. A credit pulse (`gm_credit_inc`, `lm_credit_inc`) adds one in the same cycle. If both apply, both take effect. Credits saturate at 2^CRED_W-1.
- R5: Each cycle, the histogram bin whose index equals the number of valid slots (0..N+2) goes up by one.
- R6: Each cycle exactly one of two counters goes up: the issue-cycle counter if any slot is valid, otherwise the no-issue counter.
- R7: The transition counter goes up in a cycle with no valid slot when the previous cycle had at least one.
- R8: Every cycle without issue lengthens the current idle run. The run saturates at 127. In a cycle that has an issue and follows a cycle without one, the run length L is recorded into idle bin L/5 (for L<75) or into bin 15 (for L>=75), and the run restarts at 0. The first active cycle after a clear records length 0.
- R9: No counter wraps: a counter at 2^CNT_W-1 stays there.
- R10: A synchronous `rst` or `sw_clear` sets all counters, both credits, the idle run and the previous-activity flag to zero. This takes priority over any same-cycle event.
- R11: Read map for `rd_addr`:
  - 0: issue cycles
  - 1: no-issue cycles
  - 2: transitions
  - 3+u: busy counter of unit u
  - 3+(N+2)+u: stall counter of unit u
  - next N+3 addresses: busy-count bins 0..N+2
  - next 16: idle bins 0..15
  - next 2: global credit, then local credit
  - Any higher address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_clear | input | 1 | Synchronous clear of all statistics and credits |
| slot_valid | input | NUM_SIMD+2 | Dispatch slot holds an instruction (valid) |
| simd_ready | input | NUM_SIMD | SIMD unit has an oldest instruction ready |
| gm_credit_inc | input | 1 | Add one global-memory availability credit |
| lm_credit_inc | input | 1 | Add one local-memory availability credit |
| rd_addr | input | ADDR_W | Counter read address |
| slot_clear | output | NUM_SIMD+2 | Slot consumed this cycle (ready) |
| rd_data | output | CNT_W | Value at `rd_addr` |

## Verification
`slot_clear` is combinational and is checked in the same cycle the slot inputs are applied. Every counter, bin and credit changes on the edge that samples its stimulus. Because the read port is combinational, the new value is due on `rd_data` in the cycle right after the stimulus. The bench drives inputs at the falling edge and advances its reference model once per applied cycle. At the next falling edge it compares `rd_data` against the model for the address presented, sweeping the whole map including one out-of-range address.

// File: rtl/exu_mon_pkg.sv
package exu_mon_pkg;
  localparam int IDLE_BKT_WIDTH = 5;
  localparam int IDLE_BKT_LIMIT = 75;
  localparam int IDLE_BINS      = IDLE_BKT_LIMIT / IDLE_BKT_WIDTH + 1;
  localparam int BKT_W          = $clog2(IDLE_BINS);
  localparam int RUN_W          = $clog2(IDLE_BKT_LIMIT + 1);

  // Map an idle-run length to its bin; long runs go to the last bin.
  function automatic logic [BKT_W-1:0] idle_bucket(input logic [RUN_W-1:0] len);
    if (len >= RUN_W'(IDLE_BKT_LIMIT))
      return BKT_W'(IDLE_BINS - 1);
    return BKT_W'(len / RUN_W'(IDLE_BKT_WIDTH));
  endfunction
endpackage

// File: rtl/exu_sat_counter.sv
module exu_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      q <= '0;
    else if (inc && (q != '1))
      q <= q + 1'b1;
  end
endmodule

// File: rtl/exu_mem_credit.sv
module exu_mem_credit #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic         idle,
  output logic         consume,
  output logic [W-1:0] q
);
  always_comb consume = idle && (q != '0);

  always_ff @(posedge clk) begin
    if (rst || clr)
      q <= '0;
    else begin
      unique case ({inc, consume})
        2'b10:   if (q != '1) q <= q + 1'b1;
        2'b01:   q <= q - 1'b1;
        default: q <= q;
      endcase
    end
  end
endmodule

// File: rtl/exu_idle_run.sv
module exu_idle_run
  import exu_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             active,
  output logic             prev_active,
  output logic             record,
  output logic [BKT_W-1:0] bucket,
  output logic [RUN_W-1:0] run_len
);
  always_comb begin
    record = active && !prev_active;
    bucket = idle_bucket(run_len);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      prev_active <= 1'b0;
      run_len     <= '0;
    end else begin
      prev_active <= active;
      if (record)
        run_len <= '0;
      else if (!active && (run_len != '1))
        run_len <= run_len + 1'b1;
    end
  end
endmodule

// File: rtl/exu_util_monitor.sv
module exu_util_monitor
  import exu_mon_pkg::*;
#(
  parameter int NUM_SIMD = 4,
  parameter int CNT_W    = 16,
  parameter int CRED_W   = 4,
  localparam int NUM_UNITS = NUM_SIMD + 2,
  localparam int OFS_BUSY  = 3,
  localparam int OFS_STALL = OFS_BUSY + NUM_UNITS,
  localparam int OFS_BHIST = OFS_STALL + NUM_UNITS,
  localparam int BUSY_BINS = NUM_UNITS + 1,
  localparam int OFS_IHIST = OFS_BHIST + BUSY_BINS,
  localparam int OFS_CRED  = OFS_IHIST + IDLE_BINS,
  localparam int NUM_REGS  = OFS_CRED + 2,
  localparam int ADDR_W    = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sw_clear,
  input  logic [NUM_UNITS-1:0] slot_valid,
  input  logic [NUM_SIMD-1:0]  simd_ready,
  input  logic                 gm_credit_inc,
  input  logic                 lm_credit_inc,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [NUM_UNITS-1:0] slot_clear,
  output logic [CNT_W-1:0]     rd_data
);
  localparam int GM_IDX = NUM_SIMD;
  localparam int LM_IDX = NUM_SIMD + 1;
  localparam int BUSY_W = $clog2(BUSY_BINS);

  logic [BUSY_W-1:0] busy_cnt;
  logic              any_issue;
  logic              prev_active;
  logic              idle_record;
  logic [BKT_W-1:0]  idle_bkt;
  logic [RUN_W-1:0]  run_len;
  logic              gm_take, lm_take;
  logic [CRED_W-1:0] gm_credit_q, lm_credit_q;
  logic [OFS_CRED-1:0] cnt_inc;
  logic [CNT_W-1:0]    cnt_q [OFS_CRED];

  // Slots are always accepted: ready follows valid in the same cycle.
  always_comb begin
    slot_clear = slot_valid;
    busy_cnt   = BUSY_W'($countones(slot_valid));
    any_issue  = |slot_valid;
  end

  exu_idle_run u_run (
    .clk(clk), .rst(rst), .clr(sw_clear), .active(any_issue),
    .prev_active(prev_active), .record(idle_record),
    .bucket(idle_bkt), .run_len(run_len)
  );

  exu_mem_credit #(.W(CRED_W)) u_gm_cred (
    .clk(clk), .rst(rst), .clr(sw_clear), .inc(gm_credit_inc),
    .idle(!slot_valid[GM_IDX]), .consume(gm_take), .q(gm_credit_q)
  );

  exu_mem_credit #(.W(CRED_W)) u_lm_cred (
    .clk(clk), .rst(rst), .clr(sw_clear), .inc(lm_credit_inc),
    .idle(!slot_valid[LM_IDX]), .consume(lm_take), .q(lm_credit_q)
  );

  // Global cycle and transition events.
  always_comb begin
    cnt_inc[0] = any_issue;
    cnt_inc[1] = !any_issue;
    cnt_inc[2] = prev_active && !any_issue;
  end

  // Per-unit busy and stall events.
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign cnt_inc[OFS_BUSY + u] = slot_valid[u];
    if (u < NUM_SIMD) begin : g_simd
      assign cnt_inc[OFS_STALL + u] = !slot_valid[u] && simd_ready[u];
    end else if (u == GM_IDX) begin : g_gm
      assign cnt_inc[OFS_STALL + u] = gm_take;
    end else begin : g_lm
      assign cnt_inc[OFS_STALL + u] = lm_take;
    end
  end

  // Busy-count histogram.
  for (genvar b = 0; b < BUSY_BINS; b++) begin : g_bhist
    assign cnt_inc[OFS_BHIST + b] = (busy_cnt == BUSY_W'(b));
  end

  // Idle-run-length histogram.
  for (genvar k = 0; k < IDLE_BINS; k++) begin : g_ihist
    assign cnt_inc[OFS_IHIST + k] = idle_record && (idle_bkt == BKT_W'(k));
  end

  for (genvar c = 0; c < OFS_CRED; c++) begin : g_cnt
    exu_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(sw_clear), .inc(cnt_inc[c]), .q(cnt_q[c])
    );
  end

  // Read port.
  always_comb begin
    rd_data = '0;
    for (int k = 0; k < OFS_CRED; k++)
      if (rd_addr == ADDR_W'(k)) rd_data = cnt_q[k];
    if (rd_addr == ADDR_W'(OFS_CRED))     rd_data = CNT_W'(gm_credit_q);
    if (rd_addr == ADDR_W'(OFS_CRED + 1)) rd_data = CNT_W'(lm_credit_q);
  end
endmodule

// File: rtl/exu_util_monitor_chk.sv
module exu_util_monitor_chk #(
  parameter int CNT_W  = 16,
  parameter int CRED_W = 4,
  parameter int RUN_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              sw_clear,
  input logic [CNT_W-1:0]  rd_data,
  input logic [CNT_W-1:0]  issue_q,
  input logic              record,
  input logic [RUN_W-1:0]  run_len,
  input logic [CRED_W-1:0] gm_q
);
  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    sw_clear |=> (rd_data == '0));

  // R6
  issue_step_chk: assert property (@(posedge clk) disable iff (rst)
    !sw_clear |=> ((issue_q - $past(issue_q)) <= CNT_W'(1)));

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ((issue_q == '1) && !sw_clear) |=> (issue_q == '1));

  // R8
  run_restart_chk: assert property (@(posedge clk) disable iff (rst)
    record |=> (run_len == '0));

  // R4
  credit_step_chk: assert property (@(posedge clk) disable iff (rst)
    !sw_clear |=> (((gm_q - $past(gm_q)) <= CRED_W'(1)) ||
                   (($past(gm_q) - gm_q) <= CRED_W'(1))));
endmodule

bind exu_util_monitor exu_util_monitor_chk #(
  .CNT_W(CNT_W), .CRED_W(CRED_W), .RUN_W(exu_mon_pkg::RUN_W)
) u_chk (
  .clk(clk), .rst(rst), .sw_clear(sw_clear), .rd_data(rd_data),
  .issue_q(cnt_q[0]), .record(idle_record), .run_len(run_len),
  .gm_q(gm_credit_q)
);

// File: tb/exu_util_monitor_test.sv
module exu_util_monitor_test;
  localparam int NS    = 4;
  localparam int CW    = 8;
  localparam int CRW   = 4;
  localparam int NU    = NS + 2;
  localparam int A_BSY = 3;
  localparam int A_STL = A_BSY + NU;
  localparam int A_BH  = A_STL + NU;
  localparam int A_IH  = A_BH + NU + 1;
  localparam int A_CR  = A_IH + 16;
  localparam int NREG  = A_CR + 2;
  localparam int AW    = $clog2(NREG);
  localparam int MAXC  = (1 << CW) - 1;
  localparam int MAXCR = (1 << CRW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_clear = 1'b0;
  logic [NU-1:0] slot_valid = '0;
  logic [NS-1:0] simd_ready = '0;
  logic gm_inc = 1'b0, lm_inc = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [NU-1:0] slot_clear;
  logic [CW-1:0] rd_data;

  always #10 clk = ~clk;

  exu_util_monitor #(.NUM_SIMD(NS), .CNT_W(CW), .CRED_W(CRW)) uut (
    .clk(clk), .rst(rst), .sw_clear(sw_clear), .slot_valid(slot_valid),
    .simd_ready(simd_ready), .gm_credit_inc(gm_inc), .lm_credit_inc(lm_inc),
    .rd_addr(rd_addr), .slot_clear(slot_clear), .rd_data(rd_data)
  );

  int m [NREG];
  int prev_act = 0, run = 0;
  bit cleared = 1'b1;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  function automatic string tag_of(int a, int e);
    if (cleared)                return "R10";
    if (a >= NREG)              return "R11";
    if (a < A_CR && e == MAXC)  return "R9";
    if (a < 2)                  return "R6";
    if (a == 2)                 return "R7";
    if (a < A_STL)              return "R2";
    if (a < A_STL + NS)         return "R3";
    if (a < A_BH)               return "R4";
    if (a < A_IH)               return "R5";
    if (a < A_CR)               return "R8";
    return "R4";
  endfunction

  function automatic int sat(int v);
    return (v >= MAXC) ? MAXC : v + 1;
  endfunction

  task automatic check_read();
    int a, e;
    a = int'(rd_addr);
    e = (a < NREG) ? m[a] : 0;
    n_chk++;
    if (int'(rd_data) != e) begin
      n_bad++;
      $display("FAIL %s R11 addr=%0d actual=%0d expected=%0d", tag_of(a, e), a, rd_data, e);
    end
  endtask

  task automatic model_step(logic [NU-1:0] v, logic [NS-1:0] r, bit gi, bit li, bit clr);
    int nb, dec;
    if (clr) begin
      foreach (m[k]) m[k] = 0;
      prev_act = 0; run = 0; cleared = 1'b1;
      return;
    end
    cleared = 1'b0;
    nb = $countones(v);
    for (int u = 0; u < NU; u++) begin
      if (v[u]) m[A_BSY + u] = sat(m[A_BSY + u]);
      else if (u < NS && r[u]) m[A_STL + u] = sat(m[A_STL + u]);
    end
    dec = (!v[NS] && m[A_CR] > 0) ? 1 : 0;
    if (dec == 1) m[A_STL + NS] = sat(m[A_STL + NS]);
    m[A_CR] = m[A_CR] - dec + (gi ? 1 : 0);
    if (m[A_CR] > MAXCR) m[A_CR] = MAXCR;
    dec = (!v[NS+1] && m[A_CR+1] > 0) ? 1 : 0;
    if (dec == 1) m[A_STL + NS + 1] = sat(m[A_STL + NS + 1]);
    m[A_CR+1] = m[A_CR+1] - dec + (li ? 1 : 0);
    if (m[A_CR+1] > MAXCR) m[A_CR+1] = MAXCR;
    m[A_BH + nb] = sat(m[A_BH + nb]);
    if (nb > 0) m[0] = sat(m[0]); else m[1] = sat(m[1]);
    if (prev_act == 1 && nb == 0) m[2] = sat(m[2]);
    if (nb > 0 && prev_act == 0) begin
      m[A_IH + ((run >= 75) ? 15 : run / 5)] = sat(m[A_IH + ((run >= 75) ? 15 : run / 5)]);
      run = 0;
    end else if (nb == 0 && run < 127) begin
      run++;
    end
    prev_act = (nb > 0) ? 1 : 0;
  endtask

  task automatic cyc(logic [NU-1:0] v, logic [NS-1:0] r, bit gi, bit li, bit sc, bit rs);
    @(negedge clk);
    check_read();
    slot_valid = v; simd_ready = r; gm_inc = gi; lm_inc = li;
    sw_clear = sc; rst = rs;
    rd_addr = (int'(rd_addr) >= NREG) ? '0 : rd_addr + 1'b1;
    #1;
    n_chk++;
    if (slot_clear !== v) begin
      n_bad++;
      $display("FAIL R1 slot_clear actual=%b expected=%b", slot_clear, v);
    end
    model_step(v, r, gi, li, sc || rs);
  endtask

  task automatic rand_cycles(int n);
    for (int i = 0; i < n; i++)
      cyc(NU'($urandom), NS'($urandom), ($urandom % 3) == 0, ($urandom % 3) == 0, 1'b0, 1'b0);
  endtask

  initial begin
    foreach (m[k]) m[k] = 0;
    // R10: reset held over a full map sweep
    for (int i = 0; i <= NREG; i++) cyc('0, '1, 1'b1, 1'b1, 1'b0, 1'b1);
    // R8: first active cycle after reset records length 0
    cyc(NU'(1), '0, 1'b0, 1'b0, 1'b0, 1'b0);
    rand_cycles(250);
    // R4: build credits with pipes busy, then spend them, with a simultaneous increment
    for (int i = 0; i < 3; i++) cyc(NU'(3) << NS, '0, 1'b1, 1'b1, 1'b0, 1'b0);
    cyc('0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) cyc('0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) cyc(NU'(3) << NS, '0, 1'b1, 1'b1, 1'b0, 1'b0);
    // R3: ready ignored for busy units
    for (int i = 0; i < 8; i++) cyc(NU'(4'b0101), 4'b1111, 1'b0, 1'b0, 1'b0, 1'b0);
    // R7/R8: idle runs of several lengths, incl. overflow bin
    for (int i = 0; i < 90; i++) cyc('0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc('1, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 12; i++) cyc('0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(NU'(2), '0, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(NU'(2), '0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) cyc('0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) cyc('1, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R9: saturation under long idle and long busy stretches
    for (int i = 0; i < 300; i++) cyc('0, '1, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 300; i++) cyc('1, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    // R10: software clear held over a full sweep
    for (int i = 0; i <= NREG; i++) cyc(NU'($urandom), '1, 1'b1, 1'b1, 1'b1, 1'b0);
    rand_cycles(150);
    @(negedge clk);
    check_read();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule